// File: doc/BRIEF.md
# Paged Program-Space Read Window

This block sits on the data-read path of a 16-bit core and decides where each read goes. A read whose effective address has bit 15 clear is served from data RAM in one cycle. A read with bit 15 set goes through a 32 KB window. A 10-bit read page register selects which part of a 24-bit-wide program memory the window shows. Depending on the page value, the window returns the low 16 bits of each program word, returns only its upper byte, raises an address trap, or flags an access to the extended data region. The last of these is not served here.

Window reads are slow. The block holds a busy flag for the whole access time and reports the data with a one-cycle valid pulse. Inside a repeat loop whose pointer steps by +2 or -2, the middle iterations are sped up. The core tells the block where it is in the loop through a few sideband inputs. Writes aimed at the window cannot be carried out and are only flagged. Data RAM and program memory are behavioural arrays filled from fixed rules.

Top module: `prog_window_reader`

## Requirements
- R1: The page register `page_q` is 10 bits wide and resets to 0x001. When `page_we` is high at a clock edge, it takes `page_din` at that edge.
- R2: A read accepted with `ea[15]`=0 returns data RAM with latency 1. Word i (i = `ea[6:1]`) holds {~i, i}, with i as 8 bits. A word read returns the whole word. A byte read returns the zero-extended low byte when `ea[0]`=0 and the high byte when `ea[0]`=1.
- R3: A read accepted with `ea[15]`=1 and page 0x000 pulses `addr_trap` for one cycle after the accepting edge. `rd_valid` stays low.
- R4: A read accepted with `ea[15]`=1 and a page from 0x001 to 0x1FF pulses `ext_hit` for one cycle after the accepting edge. `rd_valid` stays low.
- R5: Pages 0x200 to 0x2FF give low-word mode. A word read returns program bits 15:0. A byte read returns bits 7:0 when `ea[0]`=0 and bits 15:8 when `ea[0]`=1, zero-extended.
- R6: Pages 0x300 to 0x3FF give upper-byte mode. A word read, or a byte read with `ea[0]`=0, returns {8'h00, bits 23:16}. A byte read with `ea[0]`=1 returns 0.
- R7: Alongside window data, `prog_addr` shows {1'b0, page[7:0], ea[14:0]}. Program word i (i = `prog_addr[8:1]`) holds {i^8'h3C, i+8'h11, ~i}, with all fields 8 bits.
- R8: `wr_req` with `ea[15]`=1 pulses `wr_nosupp` one cycle after the edge. With `ea[15]`=0 it does not.
- R9: Latency L means: the read is accepted at edge k and `rd_valid` shows after edge k+L-1. A window read outside a loop takes L=5. `busy` is high until then, and `rd_req` is ignored while `busy` is high.
- R10: With `loop_on`=1 and `ptr_step` = +2 or -2, window latency follows `loop_pos`: 0 (first iteration) takes 5, 1 (middle) takes 1, and 2 (last) takes 6.
- R11: A window read takes 5 cycles whenever `loop_irq` is high or `ptr_step` is neither +2 nor -2, whatever `loop_pos` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_we | input | 1 | Write strobe for the page register |
| page_din | input | 10 | New page value |
| page_q | output | 10 | Current page register |
| ea | input | 16 | Effective address of the read or write |
| byte_rd | input | 1 | 1 = byte read, 0 = word read |
| rd_req | input | 1 | Read request, taken when not busy |
| wr_req | input | 1 | Write attempt (only window writes are flagged) |
| loop_on | input | 1 | Read issued inside a repeat loop |
| loop_pos | input | 2 | 0 first, 1 middle, 2 last iteration |
| loop_irq | input | 1 | Iteration cut by an interrupt, or first after return |
| ptr_step | input | 4 | Signed pointer post-modify step |
| busy | output | 1 | Window access in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| prog_addr | output | 24 | Program address of the last window read |
| addr_trap | output | 1 | Trap pulse for a page-zero window read |
| ext_hit | output | 1 | Pulse for a window read in the extended region |
| wr_nosupp | output | 1 | Pulse for a write aimed at the window |

## Verification
The properties assume that the page register changes only while no window read is pending or being accepted, and that `loop_pos` never takes the value 3. The bench writes the page in its own cycle before each request and drives loop positions only from the three legal codes. The properties also assume `rd_req` is dropped as soon as it is taken. The bench pulses each request for a single edge, except in the one test that deliberately holds a request during `busy`.

// File: rtl/pwin_pkg.sv
`timescale 1ns/1ps
// Shared types and memory fill rules for the paged read window.
// Assumes callers pass indices that fit the memory depths.
package pwin_pkg;

    typedef enum logic [1:0] {
        TGT_RAM  = 2'd0,
        TGT_TRAP = 2'd1,
        TGT_EXT  = 2'd2,
        TGT_PROG = 2'd3
    } target_e;

    localparam logic [1:0] POS_FIRST = 2'd0;
    localparam logic [1:0] POS_MID   = 2'd1;
    localparam logic [1:0] POS_LAST  = 2'd2;

    // Program word contents as a function of word index.
    function automatic logic [23:0] prog_fill(input int unsigned idx);
        logic [7:0] i;
        i = idx[7:0];
        return {i ^ 8'h3C, i + 8'h11, ~i};
    endfunction

    // Data RAM word contents as a function of word index.
    function automatic logic [15:0] ram_fill(input int unsigned idx);
        logic [7:0] i;
        i = idx[7:0];
        return {~i, i};
    endfunction

endpackage

// File: rtl/pwin_decode.sv
`timescale 1ns/1ps
// Classifies a read by address half and page range, and forms the program
// address. Assumes the page is at least 10 bits wide, with the top two bits
// choosing the program lanes.
module pwin_decode
    import pwin_pkg::*;
#(
    parameter int PAGE_W  = 10,
    parameter int EA_W    = 16,
    parameter int PADDR_W = 24
) (
    input  logic [PAGE_W-1:0]  page,
    input  logic [EA_W-1:0]    ea,
    output target_e            target,
    output logic               hi_lane,
    output logic [PADDR_W-1:0] paddr
);
    localparam int OFS_W = EA_W - 1;
    localparam int PG_W  = PADDR_W - 1 - OFS_W;

    // Pick the target from the address half and the page range.
    always_comb begin
        hi_lane = page[PAGE_W-2];
        if (!ea[EA_W-1])                target = TGT_RAM;
        else if (page == '0)            target = TGT_TRAP;
        else if (!page[PAGE_W-1])       target = TGT_EXT;
        else                            target = TGT_PROG;
    end

    // Program address: forced zero, low page bits, window offset.
    assign paddr = {1'b0, page[PG_W-1:0], ea[OFS_W-1:0]};

endmodule

// File: rtl/pwin_latency.sv
`timescale 1ns/1ps
// Chooses the access time of a window read from the repeat-loop sideband.
// Assumes loop_pos is 0, 1 or 2.
module pwin_latency
    import pwin_pkg::*;
#(
    parameter int BASE_LAT = 5,
    parameter int FAST_LAT = 1,
    parameter int TAIL_LAT = 6,
    parameter int STEP_W   = 4,
    parameter int LAT_W    = $clog2(TAIL_LAT + 1)
) (
    input  logic                     loop_on,
    input  logic [1:0]               loop_pos,
    input  logic                     loop_irq,
    input  logic signed [STEP_W-1:0] step,
    output logic [LAT_W-1:0]         lat
);
    localparam logic signed [STEP_W-1:0] STEP_UP = STEP_W'(2);
    localparam logic signed [STEP_W-1:0] STEP_DN = -STEP_W'(2);

    logic fast_step;
    assign fast_step = (step == STEP_UP) || (step == STEP_DN);

    // Fast middle and slow tail only in an uninterrupted unit-step loop.
    always_comb begin
        lat = LAT_W'(BASE_LAT);
        if (loop_on && fast_step && !loop_irq) begin
            case (loop_pos)
                POS_MID:  lat = LAT_W'(FAST_LAT);
                POS_LAST: lat = LAT_W'(TAIL_LAT);
                default:  lat = LAT_W'(BASE_LAT);
            endcase
        end
    end

endmodule

// File: rtl/pwin_store.sv
`timescale 1ns/1ps
// Behavioural program memory and data RAM, filled from the package rules.
// Read-only and combinational. Assumes depths are powers of two.
module pwin_store
    import pwin_pkg::*;
#(
    parameter int PROG_DEPTH = 256,
    parameter int RAM_DEPTH  = 64,
    parameter int PIDX_W     = $clog2(PROG_DEPTH),
    parameter int RIDX_W     = $clog2(RAM_DEPTH)
) (
    input  logic [PIDX_W-1:0] prog_idx,
    input  logic [RIDX_W-1:0] ram_idx,
    output logic [23:0]       prog_word,
    output logic [15:0]       ram_word
);
    logic [23:0] prog_mem [PROG_DEPTH];
    logic [15:0] ram_mem  [RAM_DEPTH];

    // Fill each program location from its index.
    for (genvar g = 0; g < PROG_DEPTH; g++) begin : g_prog
        assign prog_mem[g] = prog_fill(g);
    end

    // Fill each data RAM location from its index.
    for (genvar h = 0; h < RAM_DEPTH; h++) begin : g_ram
        assign ram_mem[h] = ram_fill(h);
    end

    assign prog_word = prog_mem[prog_idx];
    assign ram_word  = ram_mem[ram_idx];

endmodule

// File: rtl/prog_window_reader.sv
`timescale 1ns/1ps
// Data-space read router with a paged window onto program memory.
// Low half goes to data RAM in one cycle. High half goes through the page
// register to program memory with a multi-cycle, loop-dependent latency.
// Assumes the page is not rewritten in the cycle a read is taken.
module prog_window_reader
    import pwin_pkg::*;
#(
    parameter int PAGE_W     = 10,
    parameter int EA_W       = 16,
    parameter int DATA_W     = 16,
    parameter int PADDR_W    = 24,
    parameter int STEP_W     = 4,
    parameter int PROG_DEPTH = 256,
    parameter int RAM_DEPTH  = 64,
    parameter int BASE_LAT   = 5,
    parameter int FAST_LAT   = 1,
    parameter int TAIL_LAT   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                page_we,
    input  logic [PAGE_W-1:0]   page_din,
    output logic [PAGE_W-1:0]   page_q,
    input  logic [EA_W-1:0]     ea,
    input  logic                byte_rd,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic                loop_on,
    input  logic [1:0]          loop_pos,
    input  logic                loop_irq,
    input  logic [STEP_W-1:0]   ptr_step,
    output logic                busy,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [PADDR_W-1:0]  prog_addr,
    output logic                addr_trap,
    output logic                ext_hit,
    output logic                wr_nosupp
);
    localparam int LAT_W  = $clog2(TAIL_LAT + 1);
    localparam int PIDX_W = $clog2(PROG_DEPTH);
    localparam int RIDX_W = $clog2(RAM_DEPTH);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [PAGE_W-1:0] PAGE_RST = PAGE_W'(1);

    target_e             target;
    logic                hi_lane;
    logic [PADDR_W-1:0]  paddr_c;
    logic [LAT_W-1:0]    lat_c;
    logic [23:0]         prog_word;
    logic [DATA_W-1:0]   ram_word;
    logic [DATA_W-1:0]   fmt_data;
    logic [LAT_W-1:0]    cnt;
    logic [DATA_W-1:0]   pend_data;
    logic [PADDR_W-1:0]  pend_paddr;
    logic                accept;

    pwin_decode #(.PAGE_W(PAGE_W), .EA_W(EA_W), .PADDR_W(PADDR_W)) u_decode (
        .page    (page_q),
        .ea      (ea),
        .target  (target),
        .hi_lane (hi_lane),
        .paddr   (paddr_c)
    );

    pwin_latency #(
        .BASE_LAT(BASE_LAT), .FAST_LAT(FAST_LAT), .TAIL_LAT(TAIL_LAT),
        .STEP_W(STEP_W), .LAT_W(LAT_W)
    ) u_latency (
        .loop_on  (loop_on),
        .loop_pos (loop_pos),
        .loop_irq (loop_irq),
        .step     (ptr_step),
        .lat      (lat_c)
    );

    pwin_store #(.PROG_DEPTH(PROG_DEPTH), .RAM_DEPTH(RAM_DEPTH)) u_store (
        .prog_idx  (paddr_c[PIDX_W:1]),
        .ram_idx   (ea[RIDX_W:1]),
        .prog_word (prog_word),
        .ram_word  (ram_word)
    );

    assign busy   = (cnt != '0);
    assign accept = rd_req && !busy;

    // Select the lane and byte that the target and size call for.
    always_comb begin
        fmt_data = '0;
        if (target == TGT_PROG && hi_lane) begin
            if (!(byte_rd && ea[0])) fmt_data = {{HALF_W{1'b0}}, prog_word[23:16]};
        end else if (target == TGT_PROG) begin
            if (!byte_rd)   fmt_data = prog_word[15:0];
            else if (ea[0]) fmt_data = {{HALF_W{1'b0}}, prog_word[15:8]};
            else            fmt_data = {{HALF_W{1'b0}}, prog_word[7:0]};
        end else begin
            if (!byte_rd)   fmt_data = ram_word;
            else if (ea[0]) fmt_data = {{HALF_W{1'b0}}, ram_word[DATA_W-1:HALF_W]};
            else            fmt_data = {{HALF_W{1'b0}}, ram_word[HALF_W-1:0]};
        end
    end

    // Page register, request acceptance, latency countdown and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q     <= PAGE_RST;
            cnt        <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            prog_addr  <= '0;
            addr_trap  <= 1'b0;
            ext_hit    <= 1'b0;
            wr_nosupp  <= 1'b0;
            pend_data  <= '0;
            pend_paddr <= '0;
        end else begin
            rd_valid  <= 1'b0;
            addr_trap <= 1'b0;
            ext_hit   <= 1'b0;
            wr_nosupp <= wr_req && ea[EA_W-1];
            if (page_we) page_q <= page_din;
            if (accept) begin
                case (target)
                    TGT_RAM: begin
                        rd_valid <= 1'b1;
                        rd_data  <= fmt_data;
                    end
                    TGT_TRAP: addr_trap <= 1'b1;
                    TGT_EXT:  ext_hit   <= 1'b1;
                    default: begin
                        if (lat_c == LAT_W'(1)) begin
                            rd_valid  <= 1'b1;
                            rd_data   <= fmt_data;
                            prog_addr <= paddr_c;
                        end else begin
                            cnt        <= lat_c - LAT_W'(1);
                            pend_data  <= fmt_data;
                            pend_paddr <= paddr_c;
                        end
                    end
                endcase
            end else if (busy) begin
                cnt <= cnt - LAT_W'(1);
                if (cnt == LAT_W'(1)) begin
                    rd_valid  <= 1'b1;
                    rd_data   <= pend_data;
                    prog_addr <= pend_paddr;
                end
            end
        end
    end

endmodule

// File: rtl/pwin_checker.sv
`timescale 1ns/1ps
// Protocol properties for prog_window_reader, attached by bind.
// Assumes the page is stable around each accepted read.
module pwin_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  page_q,
    input logic [15:0] ea,
    input logic        rd_req,
    input logic        wr_req,
    input logic        loop_on,
    input logic        busy,
    input logic        rd_valid,
    input logic        addr_trap,
    input logic        ext_hit,
    input logic        wr_nosupp
);
    logic take;
    assign take = rd_req && !busy;

    assert_page_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> page_q == 10'h001);

    assert_ram_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ea[15]) |=> rd_valid);

    assert_trap_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ea[15] && page_q == 10'h000) |=> (addr_trap && !rd_valid));

    assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, addr_trap, ext_hit}));

    assert_ext_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ea[15] && page_q != 10'h000 && !page_q[9]) |=> ext_hit);

    assert_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && ea[15]) |=> wr_nosupp);

    assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && ea[15]) |=> !wr_nosupp);

    assert_slow_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ea[15] && page_q[9] && !loop_on) |=> (busy && !rd_valid));

    assert_busy_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_valid);

endmodule

bind prog_window_reader pwin_checker u_pwin_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_q    (page_q),
    .ea        (ea),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .loop_on   (loop_on),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .addr_trap (addr_trap),
    .ext_hit   (ext_hit),
    .wr_nosupp (wr_nosupp)
);

// File: tb/prog_window_reader_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of reads, then directed tests.
module prog_window_reader_bench;

    typedef struct packed {
        logic [9:0]  page;
        logic [15:0] ea;
        logic        byt;
        logic [1:0]  kind;   // 0 data, 1 trap, 2 extended
        logic [15:0] data;
        logic [2:0]  lat;
        logic [23:0] paddr;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{10'h001, 16'h0010, 1'b0, 2'd0, 16'hF708, 3'd1, 24'h000000},
        '{10'h001, 16'h0011, 1'b1, 2'd0, 16'h00F7, 3'd1, 24'h000000},
        '{10'h001, 16'h0010, 1'b1, 2'd0, 16'h0008, 3'd1, 24'h000000},
        '{10'h2A2, 16'h8010, 1'b0, 2'd0, 16'h19F7, 3'd5, 24'h510010},
        '{10'h2A2, 16'h8011, 1'b1, 2'd0, 16'h0019, 3'd5, 24'h510011},
        '{10'h2A2, 16'h8010, 1'b1, 2'd0, 16'h00F7, 3'd5, 24'h510010},
        '{10'h3A2, 16'h8010, 1'b0, 2'd0, 16'h0034, 3'd5, 24'h510010},
        '{10'h3A2, 16'h8011, 1'b1, 2'd0, 16'h0000, 3'd5, 24'h510011},
        '{10'h3A2, 16'h8010, 1'b1, 2'd0, 16'h0034, 3'd5, 24'h510010},
        '{10'h000, 16'h8000, 1'b0, 2'd1, 16'h0000, 3'd1, 24'h000000},
        '{10'h000, 16'h0004, 1'b0, 2'd0, 16'hFD02, 3'd1, 24'h000000},
        '{10'h1FF, 16'h9000, 1'b0, 2'd2, 16'h0000, 3'd1, 24'h000000},
        '{10'h2FF, 16'hFFFE, 1'b0, 2'd0, 16'h1000, 3'd5, 24'h7FFFFE},
        '{10'h200, 16'h8000, 1'b0, 2'd0, 16'h11FF, 3'd5, 24'h000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_we = 1'b0;
    logic [9:0]  page_din = '0;
    logic [9:0]  page_q;
    logic [15:0] ea = '0;
    logic        byte_rd = 1'b0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic        loop_on = 1'b0;
    logic [1:0]  loop_pos = 2'd0;
    logic        loop_irq = 1'b0;
    logic [3:0]  ptr_step = 4'd2;
    logic        busy, rd_valid, addr_trap, ext_hit, wr_nosupp;
    logic [15:0] rd_data;
    logic [23:0] prog_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    prog_window_reader u_prog_window_reader (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_din(page_din),
        .page_q(page_q), .ea(ea), .byte_rd(byte_rd), .rd_req(rd_req),
        .wr_req(wr_req), .loop_on(loop_on), .loop_pos(loop_pos),
        .loop_irq(loop_irq), .ptr_step(ptr_step), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .prog_addr(prog_addr),
        .addr_trap(addr_trap), .ext_hit(ext_hit), .wr_nosupp(wr_nosupp)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Low 16 bits of program word i by the R7 fill rule.
    function automatic logic [15:0] prog_low(input logic [7:0] i);
        logic [7:0] mid;
        mid = i + 8'h11;
        return {mid, ~i};
    endfunction

    task automatic set_page(input logic [9:0] p);
        @(negedge clk);
        page_we = 1'b1; page_din = p;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    // Issue one read and measure when and how it completes.
    task automatic do_read(input logic [9:0] p, input logic [15:0] a, input logic b,
                           output int lat, output logic [1:0] kind,
                           output logic [15:0] d, output logic [23:0] pa);
        set_page(p);
        ea = a; byte_rd = b; rd_req = 1'b1;
        lat = 0; kind = 2'd3; d = '0; pa = '0;
        for (int n = 1; n <= 12; n++) begin
            @(posedge clk); #1;
            rd_req = 1'b0;
            lat = n;
            if (rd_valid)  begin kind = 2'd0; d = rd_data; pa = prog_addr; break; end
            if (addr_trap) begin kind = 2'd1; break; end
            if (ext_hit)   begin kind = 2'd2; break; end
        end
    endtask

    task automatic loop_read(input logic [15:0] a, input logic [1:0] pos,
                             input logic [3:0] st, input logic irq,
                             input int exp_lat, input string tag);
        int lat; logic [1:0] kind; logic [15:0] d; logic [23:0] pa;
        loop_on = 1'b1; loop_pos = pos; ptr_step = st; loop_irq = irq;
        do_read(10'h2A2, a, 1'b0, lat, kind, d, pa);
        check(kind == 2'd0 && lat == exp_lat, tag, lat, exp_lat);
        check(d == prog_low(8'(a[8:1])), tag, d, prog_low(8'(a[8:1])));
        loop_on = 1'b0; loop_irq = 1'b0; loop_pos = 2'd0; ptr_step = 4'd2;
    endtask

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat; logic [1:0] kind; logic [15:0] d; logic [23:0] pa;
        int pulses;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        check(page_q == 10'h001, "R1 reset page", page_q, 10'h001);
        check(!busy && !rd_valid && !addr_trap && !ext_hit, "R1 reset idle",
              {busy, rd_valid, addr_trap, ext_hit}, 0);

        // Vector table walk (R2..R7, R9)
        for (int v = 0; v < NVEC; v++) begin
            do_read(VECS[v].page, VECS[v].ea, VECS[v].byt, lat, kind, d, pa);
            check(kind == VECS[v].kind, $sformatf("R2-7 vec%0d kind (R3 R4)", v), kind, VECS[v].kind);
            check(lat == int'(VECS[v].lat), $sformatf("vec%0d latency R9", v), lat, VECS[v].lat);
            if (VECS[v].kind == 2'd0)
                check(d == VECS[v].data, $sformatf("vec%0d data R2 R5 R6", v), d, VECS[v].data);
            if (VECS[v].kind == 2'd0 && VECS[v].ea[15])
                check(pa == VECS[v].paddr, $sformatf("vec%0d address R7", v), pa, VECS[v].paddr);
        end

        // R1: page write and read-back of full width
        set_page(10'h3FF); #1;
        check(page_q == 10'h3FF, "R1 page write", page_q, 10'h3FF);

        // R8: window write flagged, low-half write not
        @(negedge clk); ea = 16'h8000; wr_req = 1'b1;
        @(posedge clk); #1; wr_req = 1'b0;
        check(wr_nosupp, "R8 window write", wr_nosupp, 1);
        @(negedge clk); ea = 16'h1000; wr_req = 1'b1;
        @(posedge clk); #1; wr_req = 1'b0;
        check(!wr_nosupp, "R8 ram write", wr_nosupp, 0);

        // R9: requests while busy are ignored
        set_page(10'h2A2);
        ea = 16'h8010; byte_rd = 1'b0; rd_req = 1'b1;
        @(posedge clk); #1;
        check(busy, "R9 busy after accept", busy, 1);
        ea = 16'h0010;
        pulses = 0;
        for (int n = 0; n < 8; n++) begin
            if (n == 2) rd_req = 1'b0;
            @(posedge clk); #1;
            if (rd_valid) begin
                pulses++;
                check(rd_data == 16'h19F7, "R9 data of first request", rd_data, 16'h19F7);
            end
        end
        check(pulses == 1, "R9 one result only", pulses, 1);

        // R10: unit-step loop timing
        loop_read(16'h8010, 2'd0, 4'd2,  1'b0, 5, "R10 first");
        loop_read(16'h8012, 2'd1, 4'd2,  1'b0, 1, "R10 middle +2");
        loop_read(16'h8014, 2'd1, 4'hE,  1'b0, 1, "R10 middle -2");
        loop_read(16'h8016, 2'd2, 4'd2,  1'b0, 6, "R10 last");
        // R11: interrupt edges and other steps
        loop_read(16'h8018, 2'd1, 4'd2,  1'b1, 5, "R11 irq middle");
        loop_read(16'h801A, 2'd2, 4'hE,  1'b1, 5, "R11 irq last");
        loop_read(16'h801C, 2'd1, 4'd4,  1'b0, 5, "R11 step 4");
        loop_read(16'h801E, 2'd2, 4'd1,  1'b0, 5, "R11 step 1 last");

        // R9: outside a loop position is ignored
        loop_on = 1'b0; loop_pos = 2'd1;
        do_read(10'h2A2, 16'h8020, 1'b0, lat, kind, d, pa);
        check(lat == 5, "R9 no loop ignores position", lat, 5);
        loop_pos = 2'd0;

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule